// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block carries one bus cycle on a 16-bit multiplexed address/data bus. A cycle runs through four fixed phases (T1, T2, T3, T4), with wait phases (TW) added between T3 and T4 for as long as the addressed target is not ready. In T1 the block raises an address latch strobe and puts the address on the shared bus. In the later phases the shared bus carries write data, or is released so that read data can be sampled. A separate full-width address bus stays driven for the whole cycle.

The cycle type picks the byte lanes. It is signalled on the pair formed by the byte-high-enable line and bit 0 of the shared bus, and one code of that pair marks a refresh cycle. A configuration strap is sampled while reset is held. When the strap is set, a per-region disable bit can drop the address phase from the shared bus, and the address then appears only on the separate bus. Readiness is the OR of a synchronous ready input and an asynchronous ready input. The asynchronous input is seen at once when it rises and only after a two-stage delay when it falls. Outputs with a tri-state enable are released during reset and while a bus hold is granted.

Top module: `busseq_top`

## Requirements
- R1: The cycle type is given on req_type as 0 = word, 1 = high byte, 2 = low byte, 3 = refresh. The pair {bhe, ad_out[0]} is driven in T1 as 00, 01, 10 and 11 respectively, so refresh is the only type with both bits high.
- R2: In idle, a request with req_valid high and hold_grant low is taken at a clock edge. The next cycle is T1, in which ale is high. ale is low in all other cycles. done is high for exactly one cycle (T4), which is the (4+W)th cycle counting T1 as the first, where W is the number of wait phases. The block then returns to idle.
- R3: bhe keeps its encoded value, with bhe_oe high, from T1 through T3, every TW and T4.
- R4: In T1, ad_oe is high unless the address phase is suppressed (R7), and ad_out = {req_addr[15:1], lane bit}. From T2 through T4, a write drives ad_out = req_wdata with ad_oe high, and a read leaves ad_oe low.
- R5: a_out equals req_addr[19:0], with a_oe high, from T1 through T4. In idle, a_oe, bhe_oe and ad_oe are low.
- R6: While rst_n is low or hold_grant is high, ad_oe, bhe_oe and a_oe are low. No request is taken while hold_grant is high.
- R7: strap_aden is sampled only while rst_n is low, and later changes have no effect. If it was sampled high, a non-refresh cycle whose region (req_region selects a bit of region_da) has its disable bit set has ad_oe low in T1.
- R8: If strap_aden was sampled low, ad_oe is high in T1 for every cycle, whatever region_da holds.
- R9: Ready is ardy (after its delay) OR srdy, sampled at the edge that ends T3 and at the edge that ends each TW. A not-ready sample adds one TW. With ardy held high, every cycle has W = 0, whatever srdy is.
- R10: A rise of ardy between edges counts as ready at the very next edge. A fall takes effect only after two clock edges, so ardy dropped during T2 still makes the cycle ready at the end of T3.
- R11: rd_data takes ad_in at the ready edge that ends the last T3 or TW phase, and holds that value until the next cycle's ready edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap sampling window |
| strap_aden | input | 1 | Address-phase suppression strap, sampled during reset |
| hold_grant | input | 1 | Bus hold granted: release driven outputs, take no request |
| req_valid | input | 1 | Cycle request |
| req_type | input | 2 | 0 word, 1 high byte, 2 low byte, 3 refresh |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_region | input | 2 | Chip-select region of the cycle |
| region_da | input | 4 | Per-region address-phase disable bits |
| ardy | input | 1 | Asynchronous ready, active high |
| srdy | input | 1 | Synchronous ready, active high |
| ad_in | input | 16 | Shared bus input for read data |
| ale | output | 1 | Address latch strobe, high in T1 |
| bhe | output | 1 | Byte-high-enable line value |
| bhe_oe | output | 1 | Drive enable for bhe |
| ad_out | output | 16 | Shared bus output value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| a_out | output | 20 | Separate address bus |
| a_oe | output | 1 | Drive enable for a_out |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | High in T4 |

## Verification
The hardest cases to reach are the two edges of ardy, because each shows up only when the input changes part-way through a cycle. The stimulus raises ardy between edges while the block is already in a wait phase and expects T4 one cycle later. It also drops ardy during T2 with srdy held low and expects no wait phase at all, since the fall has not yet reached the ready logic when T3 ends. Strap suppression is covered by resetting twice, once with the strap low and once high, with random region disable bits. After each reset the strap is toggled to show it has no effect.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } bus_state_t;

  typedef enum logic [1:0] {
    CY_WORD = 2'd0,
    CY_HIGH = 2'd1,
    CY_LOW  = 2'd2,
    CY_RFSH = 2'd3
  } cyc_t;

  // returns {bhe, ad0}
  function automatic logic [1:0] lane_code(cyc_t t);
    logic [1:0] c;
    case (t)
      CY_WORD: c = 2'b00;
      CY_HIGH: c = 2'b01;
      CY_LOW:  c = 2'b10;
      default: c = 2'b11;
    endcase
    return c;
  endfunction

  // address phase dropped from the shared bus
  function automatic logic drop_addr(logic strap, logic da_bit, cyc_t t);
    return strap && da_bit && (t != CY_RFSH);
  endfunction

endpackage

// File: rtl/busseq_rdy.sv
module busseq_rdy #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ardy,
  input  logic srdy,
  output logic ready
);
  localparam int MSB = SYNC - 1;

  logic [MSB:0] sh;

  // rising edge of ardy presets the chain at once; falling edge walks through it
  always_ff @(posedge clk or posedge ardy) begin
    if (ardy) sh <= '1;
    else      sh <= {sh[MSB-1:0], 1'b0};
  end

  assign ready = sh[MSB] | srdy;

  // ardy high at an edge keeps ready high until the next edge
  p_ardy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ardy) |-> ready);

endmodule

// File: rtl/busseq_strap.sv
module busseq_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic strap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  p_strap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q));

endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
#(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_grant,
  input  logic          strap_q,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [RW-1:0] req_region,
  input  logic [NREG-1:0] region_da,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output bus_state_t    state,
  output cyc_t          q_type,
  output logic          q_write,
  output logic          q_drop,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata,
  output logic [DW-1:0] rd_data
);
  bus_state_t nxt;
  logic       accept;
  logic       capture;

  assign accept  = (state == S_IDLE) && req_valid && !hold_grant;
  assign capture = ((state == S_T3) || (state == S_TW)) && ready;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:      if (accept) nxt = S_T1;
      S_T1:        nxt = S_T2;
      S_T2:        nxt = S_T3;
      S_T3, S_TW:  nxt = ready ? S_T4 : S_TW;
      S_T4:        nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q_type  <= CY_WORD;
      q_write <= 1'b0;
      q_drop  <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      rd_data <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        q_type  <= cyc_t'(req_type);
        q_write <= req_write;
        q_drop  <= drop_addr(strap_q, region_da[req_region], cyc_t'(req_type));
        q_addr  <= req_addr;
        q_wdata <= req_wdata;
      end
      if (capture) rd_data <= ad_in;
    end
  end

  p_wait_on_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_T3 || state == S_TW) && !ready) |=> (state == S_TW));

  p_t4_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T4) |=> (state == S_IDLE));

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_T3 || state == S_TW) && ready) |=> (rd_data == $past(ad_in)));

  p_no_take_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && hold_grant) |=> (state == S_IDLE));

endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int SYNC = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap_aden,
  input  logic            hold_grant,
  input  logic            req_valid,
  input  logic [1:0]      req_type,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [RW-1:0]   req_region,
  input  logic [NREG-1:0] region_da,
  input  logic            ardy,
  input  logic            srdy,
  input  logic [DW-1:0]   ad_in,
  output logic            ale,
  output logic            bhe,
  output logic            bhe_oe,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [AW-1:0]   a_out,
  output logic            a_oe,
  output logic [DW-1:0]   rd_data,
  output logic            done
);
  logic          ready;
  logic          strap_q;
  bus_state_t    state;
  cyc_t          q_type;
  logic          q_write;
  logic          q_drop;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [1:0]    lanes;
  logic          in_cycle;
  logic          may_drive;

  busseq_rdy #(.SYNC(SYNC)) u_rdy (
    .clk(clk), .rst_n(rst_n), .ardy(ardy), .srdy(srdy), .ready(ready)
  );

  busseq_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_aden), .strap_q(strap_q)
  );

  busseq_fsm #(.AW(AW), .DW(DW), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_grant(hold_grant), .strap_q(strap_q),
    .req_valid(req_valid), .req_type(req_type), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_region(req_region),
    .region_da(region_da), .ready(ready), .ad_in(ad_in), .state(state),
    .q_type(q_type), .q_write(q_write), .q_drop(q_drop), .q_addr(q_addr),
    .q_wdata(q_wdata), .rd_data(rd_data)
  );

  assign lanes     = lane_code(q_type);
  assign in_cycle  = (state != S_IDLE);
  assign may_drive = rst_n && !hold_grant;

  always_comb begin
    ale    = (state == S_T1);
    done   = (state == S_T4);
    bhe    = in_cycle ? lanes[1] : 1'b0;
    bhe_oe = in_cycle && may_drive;
    a_out  = q_addr;
    a_oe   = in_cycle && may_drive;
    if (state == S_T1) begin
      ad_out = {q_addr[DW-1:1], lanes[0]};
      ad_oe  = !q_drop && may_drive;
    end else begin
      ad_out = q_wdata;
      ad_oe  = in_cycle && q_write && may_drive;
    end
  end

  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_grant |-> (!ad_oe && !bhe_oe && !a_oe));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_bhe_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T2 || state == S_T3 || state == S_TW || state == S_T4) |-> $stable(bhe));

  p_strap_low_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !strap_q && !hold_grant) |-> ad_oe);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cycle |-> (!a_oe && !bhe_oe && !ad_oe));

endmodule

// File: tb/busseq_top_bench.sv
module busseq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_aden = 1'b0;
  logic        hold_grant = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = 2'd0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_region = '0;
  logic [3:0]  region_da = '0;
  logic        ardy = 1'b0;
  logic        srdy = 1'b0;
  logic [15:0] ad_in = '0;
  logic        ale, bhe, bhe_oe, ad_oe, a_oe, done;
  logic [15:0] ad_out, rd_data;
  logic [19:0] a_out;

  int checks = 0;
  int errors = 0;
  bit strap_phase = 1'b0;

  always #2 clk = ~clk;

  busseq_top u_busseq_top (
    .clk(clk), .rst_n(rst_n), .strap_aden(strap_aden), .hold_grant(hold_grant),
    .req_valid(req_valid), .req_type(req_type), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_region(req_region),
    .region_da(region_da), .ardy(ardy), .srdy(srdy), .ad_in(ad_in),
    .ale(ale), .bhe(bhe), .bhe_oe(bhe_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_out(a_out), .a_oe(a_oe), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // lane pair {bhe, ad0} restated from the type table
  function automatic logic [1:0] exp_lane(input logic [1:0] t);
    return {(t == 2'd2) || (t == 2'd3), (t == 2'd1) || (t == 2'd3)};
  endfunction

  function automatic bit exp_drop(input bit strap, input logic [3:0] da,
                                  input logic [1:0] reg_i, input logic [1:0] t);
    if (!strap) return 1'b0;
    if (t == 2'd3) return 1'b0;
    return da[reg_i];
  endfunction

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_aden = strap;
    strap_phase = strap;
    repeat (3) @(negedge clk);
    chk(!ad_oe && !bhe_oe && !a_oe, "R6 reset oe", {ad_oe, bhe_oe, a_oe}, 0);
    chk(!ale && !done, "R2 reset ale/done", {ale, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_aden = !strap;   // R7: later strap changes ignored
  endtask

  // called at a negedge with the block idle
  task automatic run_cycle(input logic [1:0] t, input logic [19:0] addr,
                           input logic [15:0] wd, input bit wr,
                           input logic [1:0] rg, input bit ardy0,
                           input int chg_k, input bit chg_v,
                           input int srdy_from, input int expw);
    logic [1:0]  ln;
    logic [15:0] base;
    bit          drop;
    int          k;
    ln   = exp_lane(t);
    drop = exp_drop(strap_phase, region_da, rg, t);
    base = 16'($urandom);
    req_type = t; req_addr = addr; req_wdata = wd; req_write = wr;
    req_region = rg; ardy = ardy0; srdy = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (1) begin
      if (k == chg_k) ardy = chg_v;
      srdy  = (k >= srdy_from);
      ad_in = base ^ 16'(k);
      if (k == 0) begin
        chk(ale == 1'b1, "R2 ale in T1", ale, 1);
        chk(ad_oe == !drop, "R7/R8 T1 ad_oe", ad_oe, !drop);
        if (!drop)
          chk(ad_out == {addr[15:1], ln[0]}, "R4 T1 ad_out", ad_out, {addr[15:1], ln[0]});
        chk(bhe_oe && bhe == ln[1], "R1 bhe code", bhe, ln[1]);
        chk(a_oe && a_out == addr, "R5 a_out", a_out, addr);
      end else begin
        chk(!ale, "R2 ale low", ale, 0);
        chk(ad_oe == wr, "R4 data ad_oe", ad_oe, wr);
        if (wr) chk(ad_out == wd, "R4 write data", ad_out, wd);
        chk(bhe_oe && bhe == ln[1], "R3 bhe held", bhe, ln[1]);
        chk(a_oe && a_out == addr, "R5 a_out held", a_out, addr);
      end
      if (done) break;
      if (k > 40) break;
      k++;
      @(negedge clk);
    end
    chk(k == 3 + expw, "R9/R10 cycle length", k, 3 + expw);
    @(negedge clk);
    chk(!done && !ale, "R2 back to idle", done, 0);
    chk(!a_oe && !bhe_oe && !ad_oe, "R5 idle release", {a_oe, bhe_oe, ad_oe}, 0);
    chk(rd_data == (base ^ 16'(2 + expw)), "R11 rd_data", rd_data, base ^ 16'(2 + expw));
  endtask

  task automatic rand_cycle();
    logic [1:0] t;
    int w;
    t = 2'($urandom);
    w = int'($urandom % 6);
    if ($urandom % 3 == 0)
      run_cycle(t, 20'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
                1'b1, -1, 1'b1, 1000, 0);                       // R9 ardy high
    else
      run_cycle(t, 20'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
                1'b0, -1, 1'b0, 2 + w, w);                      // R9 srdy waits
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    // phase 1: strap low
    region_da = 4'hF;
    do_reset(1'b0);
    // R1 every type, R8 no suppression despite all DA bits set
    for (int t = 0; t < 4; t++)
      run_cycle(2'(t), 20'hA5C3E ^ 20'(t), 16'h1234, 1'b0, 2'(t), 1'b1, -1, 1'b1, 1000, 0);
    run_cycle(2'd0, 20'h0FFFF, 16'hBEEF, 1'b1, 2'd1, 1'b0, -1, 1'b0, 2, 0);
    // R10 fall of ardy during T2 not yet seen at end of T3
    run_cycle(2'd2, 20'h12345, 16'h0, 1'b0, 2'd0, 1'b1, 1, 1'b0, 1000, 0);
    // R10 rise of ardy in the second wait phase
    run_cycle(2'd1, 20'h54321, 16'hCAFE, 1'b1, 2'd2, 1'b0, 4, 1'b1, 1000, 2);
    ardy = 1'b0;
    // R6 hold blocks request and releases outputs
    @(negedge clk);
    hold_grant = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ale && !done, "R6 no take under hold", ale, 0);
      chk(!ad_oe && !bhe_oe && !a_oe, "R6 hold oe", {ad_oe, bhe_oe, a_oe}, 0);
    end
    hold_grant = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) rand_cycle();
    // phase 2: strap high, random DA bits
    region_da = 4'b0101;
    do_reset(1'b1);
    for (int t = 0; t < 4; t++)
      run_cycle(2'(t), 20'h3C3C3, 16'h5A5A, 1'b1, 2'd0, 1'b1, -1, 1'b1, 1000, 0); // R7 refresh keeps addr
    run_cycle(2'd0, 20'h3C3C3, 16'h5A5A, 1'b0, 2'd1, 1'b1, -1, 1'b1, 1000, 0);
    for (int i = 0; i < 60; i++) begin
      region_da = 4'($urandom);
      rand_cycle();
    end
    finish_up();
  end

endmodule